// File: doc/BRIEF.md
# Vector Micro-op Expansion Unit

This block takes one decoded vector instruction whose operand size is not fixed by its opcode. It turns that instruction into a run of micro-ops, one per general-purpose register, and hands them to a micro-op queue.

A 3-bit format selector in the instruction picks one byte-length field from a packed length register. It also picks the lane-size field with the same number from a packed lane-size register. The block sizes the run from the selected byte length: each register holds 8 bytes, so the micro-op count is the length divided by 8, rounded up. Each micro-op carries:
- the opcode, unchanged;
- the lane-size code, unchanged;
- register indices that step by one from the instruction's base registers;
- a byte-enable mask, which trims the partial tail on the last micro-op;
- a last flag on the final micro-op.

Both configuration registers are captured when the instruction is taken in, so later writes to them do not affect a run already in progress. If the lane-size code is illegal or the length is out of range, the block emits no micro-ops and raises a one-cycle exception pulse instead.

Top module: `vuop_expander`

## Requirements
- R1: After a synchronous reset, `in_ready_o` is 1, and both `uop_valid_o` and `exc_o` are 0.
- R2: Format value f selects the length field at bits [7f+6:7f] of `cfg_len_i` and the lane code at bits [3f+2:3f] of `cfg_lane_i`.
- R3: A selected length L from 1 to 64 produces exactly ceil(L/8) micro-ops. L = 0 produces none, raises no exception, and leaves `in_ready_o` at 1.
- R4: Micro-op k, counting from 0, carries `uop_idx_o` = k, `uop_src_o` = base source + k and `uop_dst_o` = base destination + k, both modulo 64.
- R5: Only the final micro-op has `uop_last_o` = 1. Byte b of `uop_byte_en_o` on micro-op k is 1 exactly when 8k + b < L, so every earlier micro-op has a mask of 0xFF.
- R6: `uop_opcode_o` equals the accepted opcode, and `uop_lane_o` equals the selected lane code, whatever the format.
- R7: A lane code of 5, 6 or 7 (legal codes 0 to 4 stand for 1, 2, 4, 8 and 16 bytes), or a length above 64, raises `exc_o` for exactly the cycle after acceptance. No micro-ops are emitted.
- R8: While `uop_ready_i` is 0, the presented micro-op stays valid and all of its fields hold.
- R9: `in_ready_o` is 0 from the cycle after an expanding instruction is accepted until its final micro-op is handed over. The cycle after that handover, it is 1 and `uop_valid_o` is 0.
- R10: Changes to `cfg_len_i` or `cfg_lane_i` after acceptance do not affect the micro-ops of that instruction.
- R11: A synchronous reset during expansion drops the rest of the run. The cycle after reset, `uop_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_len_i | input | 56 | Eight packed 7-bit byte-length fields |
| cfg_lane_i | input | 24 | Eight packed 3-bit lane-size codes |
| in_valid_i | input | 1 | Instruction present |
| in_ready_o | output | 1 | Block can take an instruction |
| in_opcode_i | input | 8 | Operation code |
| in_fmt_i | input | 3 | Format selector |
| in_src_i | input | 6 | Base source register |
| in_dst_i | input | 6 | Base destination register |
| uop_valid_o | output | 1 | Micro-op present |
| uop_ready_i | input | 1 | Queue can take a micro-op |
| uop_opcode_o | output | 8 | Operation code passed through |
| uop_src_o | output | 6 | Source register of this micro-op |
| uop_dst_o | output | 6 | Destination register of this micro-op |
| uop_lane_o | output | 3 | Lane-size code |
| uop_idx_o | output | 3 | Position within the run |
| uop_last_o | output | 1 | Final micro-op of the run |
| uop_byte_en_o | output | 8 | Byte enables for this register |
| exc_o | output | 1 | Illegal format exception pulse |

## Verification
A corrupted step counter shows up at once on the next micro-op. Its register indices or its position in the run would be off by one, or the last flag would land on the wrong beat. A count taken from the wrong field shows up one handover later, when `in_ready_o` rises too early or too late. A snapshot that is not held would change the tail mask on the final micro-op. Because that beat appears only after all earlier ones, the bench uses long runs with a configuration write in the middle of the run.

// File: rtl/vuop_pkg.sv
package vuop_pkg;
  localparam int unsigned VU_NUM_FMT       = 8;
  localparam int unsigned VU_LEN_W         = 7;
  localparam int unsigned VU_LANE_W        = 3;
  localparam int unsigned VU_BYTES_PER_REG = 8;
  localparam int unsigned VU_MAX_REGS      = 8;
  localparam int unsigned VU_REG_W         = 6;
  localparam int unsigned VU_OP_W          = 8;

  typedef enum logic [2:0] {
    LANE_B1  = 3'd0,
    LANE_B2  = 3'd1,
    LANE_B4  = 3'd2,
    LANE_B8  = 3'd3,
    LANE_B16 = 3'd4
  } lane_code_e;

  localparam int unsigned VU_LANE_MAX_LEGAL = 4;
endpackage

// File: rtl/vuop_fmt_sel.sv
module vuop_fmt_sel #(
  parameter int unsigned NUM_FMT       = vuop_pkg::VU_NUM_FMT,
  parameter int unsigned LEN_W         = vuop_pkg::VU_LEN_W,
  parameter int unsigned LANE_W        = vuop_pkg::VU_LANE_W,
  parameter int unsigned BYTES_PER_REG = vuop_pkg::VU_BYTES_PER_REG,
  parameter int unsigned MAX_REGS      = vuop_pkg::VU_MAX_REGS,
  localparam int unsigned FMT_W        = $clog2(NUM_FMT),
  localparam int unsigned NCNT_W       = $clog2(MAX_REGS + 1)
) (
  input  logic [NUM_FMT*LEN_W-1:0]  len_reg_i,
  input  logic [NUM_FMT*LANE_W-1:0] lane_reg_i,
  input  logic [FMT_W-1:0]          fmt_i,
  output logic [LEN_W-1:0]          sel_len_o,
  output logic [LANE_W-1:0]         sel_lane_o,
  output logic [NCNT_W-1:0]         nregs_o,
  output logic                      cfg_bad_o
);
  localparam int unsigned MAX_LEN = BYTES_PER_REG * MAX_REGS;

  // registers spanned by a byte length, rounded up
  function automatic logic [NCNT_W-1:0] regs_needed(input logic [LEN_W-1:0] len);
    int unsigned n;
    n = (32'(len) + BYTES_PER_REG - 1) / BYTES_PER_REG;
    return NCNT_W'(n);
  endfunction

  function automatic logic lane_legal(input logic [LANE_W-1:0] code);
    return 32'(code) <= vuop_pkg::VU_LANE_MAX_LEGAL;
  endfunction

  logic [LEN_W-1:0]  len_f  [NUM_FMT];
  logic [LANE_W-1:0] lane_f [NUM_FMT];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_field
    assign len_f[g]  = len_reg_i[g*LEN_W +: LEN_W];
    assign lane_f[g] = lane_reg_i[g*LANE_W +: LANE_W];
  end

  assign sel_len_o  = len_f[fmt_i];
  assign sel_lane_o = lane_f[fmt_i];
  assign nregs_o    = regs_needed(sel_len_o);
  assign cfg_bad_o  = !lane_legal(sel_lane_o) || (32'(sel_len_o) > MAX_LEN);
endmodule

// File: rtl/vuop_seq.sv
module vuop_seq #(
  parameter int unsigned LEN_W    = vuop_pkg::VU_LEN_W,
  parameter int unsigned LANE_W   = vuop_pkg::VU_LANE_W,
  parameter int unsigned MAX_REGS = vuop_pkg::VU_MAX_REGS,
  parameter int unsigned REG_W    = vuop_pkg::VU_REG_W,
  parameter int unsigned OP_W     = vuop_pkg::VU_OP_W,
  localparam int unsigned NCNT_W  = $clog2(MAX_REGS + 1),
  localparam int unsigned IDX_W   = $clog2(MAX_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              cfg_bad_i,
  input  logic [NCNT_W-1:0] nregs_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [REG_W-1:0]  src_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic              uop_ready_i,
  output logic              busy_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [NCNT_W-1:0] nregs_q_o,
  output logic [LEN_W-1:0]  len_q_o,
  output logic [LANE_W-1:0] lane_q_o,
  output logic [OP_W-1:0]   op_q_o,
  output logic [REG_W-1:0]  src_q_o,
  output logic [REG_W-1:0]  dst_q_o,
  output logic              exc_o
);
  logic              busy_q, exc_q;
  logic [IDX_W-1:0]  idx_q;
  logic [NCNT_W-1:0] nregs_q;
  logic [LEN_W-1:0]  len_q;
  logic [LANE_W-1:0] lane_q;
  logic [OP_W-1:0]   op_q;
  logic [REG_W-1:0]  src_q, dst_q;

  // named events
  logic acc_evt, fire_evt, fin_evt, start_evt;
  assign acc_evt   = in_valid_i && !busy_q;
  assign start_evt = acc_evt && !cfg_bad_i && (nregs_i != '0);
  assign fire_evt  = busy_q && uop_ready_i;
  assign fin_evt   = fire_evt && (NCNT_W'(idx_q) == nregs_q - NCNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      exc_q   <= 1'b0;
      idx_q   <= '0;
      nregs_q <= '0;
      len_q   <= '0;
      lane_q  <= '0;
      op_q    <= '0;
      src_q   <= '0;
      dst_q   <= '0;
    end else begin
      exc_q <= acc_evt && cfg_bad_i;
      if (acc_evt) begin
        nregs_q <= nregs_i;
        len_q   <= len_i;
        lane_q  <= lane_i;
        op_q    <= op_i;
        src_q   <= src_i;
        dst_q   <= dst_i;
        idx_q   <= '0;
        busy_q  <= start_evt;
      end else if (fin_evt) begin
        busy_q <= 1'b0;
      end else if (fire_evt) begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assign in_ready_o = !busy_q;
  assign busy_o     = busy_q;
  assign idx_o      = idx_q;
  assign nregs_q_o  = nregs_q;
  assign len_q_o    = len_q;
  assign lane_q_o   = lane_q;
  assign op_q_o     = op_q;
  assign src_q_o    = src_q;
  assign dst_q_o    = dst_q;
  assign exc_o      = exc_q;

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (NCNT_W'(idx_q) < nregs_q)); // R3
  AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (rst)
    busy_q && !fin_evt |=> busy_q && $stable(nregs_q) && $stable(len_q) && $stable(lane_q)); // R10
  AST_EXC_QUIET: assert property (@(posedge clk) disable iff (rst)
    exc_q |-> !busy_q); // R7
  AST_STALL_IDX: assert property (@(posedge clk) disable iff (rst)
    busy_q && !uop_ready_i |=> busy_q && $stable(idx_q)); // R8
endmodule

// File: rtl/vuop_emit.sv
module vuop_emit #(
  parameter int unsigned LEN_W         = vuop_pkg::VU_LEN_W,
  parameter int unsigned BYTES_PER_REG = vuop_pkg::VU_BYTES_PER_REG,
  parameter int unsigned MAX_REGS      = vuop_pkg::VU_MAX_REGS,
  parameter int unsigned REG_W         = vuop_pkg::VU_REG_W,
  localparam int unsigned NCNT_W       = $clog2(MAX_REGS + 1),
  localparam int unsigned IDX_W        = $clog2(MAX_REGS)
) (
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [NCNT_W-1:0]        nregs_i,
  input  logic [LEN_W-1:0]         len_i,
  input  logic [REG_W-1:0]         src_i,
  input  logic [REG_W-1:0]         dst_i,
  output logic [REG_W-1:0]         src_o,
  output logic [REG_W-1:0]         dst_o,
  output logic                     last_o,
  output logic [BYTES_PER_REG-1:0] byte_en_o
);
  // enables for the final register: low (len mod width) bytes, or all
  function automatic logic [BYTES_PER_REG-1:0] tail_mask(input logic [LEN_W-1:0] len);
    int unsigned rem;
    logic [BYTES_PER_REG-1:0] m;
    rem = 32'(len) % BYTES_PER_REG;
    m = '1;
    if (rem != 0) m = BYTES_PER_REG'((1 << rem) - 1);
    return m;
  endfunction

  assign src_o     = src_i + REG_W'(idx_i);
  assign dst_o     = dst_i + REG_W'(idx_i);
  assign last_o    = (NCNT_W'(idx_i) == nregs_i - NCNT_W'(1));
  assign byte_en_o = last_o ? tail_mask(len_i) : '1;
endmodule

// File: rtl/vuop_expander.sv
module vuop_expander #(
  parameter int unsigned NUM_FMT       = vuop_pkg::VU_NUM_FMT,
  parameter int unsigned LEN_W         = vuop_pkg::VU_LEN_W,
  parameter int unsigned LANE_W        = vuop_pkg::VU_LANE_W,
  parameter int unsigned BYTES_PER_REG = vuop_pkg::VU_BYTES_PER_REG,
  parameter int unsigned MAX_REGS      = vuop_pkg::VU_MAX_REGS,
  parameter int unsigned REG_W         = vuop_pkg::VU_REG_W,
  parameter int unsigned OP_W          = vuop_pkg::VU_OP_W,
  localparam int unsigned FMT_W        = $clog2(NUM_FMT),
  localparam int unsigned IDX_W        = $clog2(MAX_REGS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_FMT*LEN_W-1:0]  cfg_len_i,
  input  logic [NUM_FMT*LANE_W-1:0] cfg_lane_i,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [OP_W-1:0]           in_opcode_i,
  input  logic [FMT_W-1:0]          in_fmt_i,
  input  logic [REG_W-1:0]          in_src_i,
  input  logic [REG_W-1:0]          in_dst_i,
  output logic                      uop_valid_o,
  input  logic                      uop_ready_i,
  output logic [OP_W-1:0]           uop_opcode_o,
  output logic [REG_W-1:0]          uop_src_o,
  output logic [REG_W-1:0]          uop_dst_o,
  output logic [LANE_W-1:0]         uop_lane_o,
  output logic [IDX_W-1:0]          uop_idx_o,
  output logic                      uop_last_o,
  output logic [BYTES_PER_REG-1:0]  uop_byte_en_o,
  output logic                      exc_o
);
  localparam int unsigned NCNT_W = $clog2(MAX_REGS + 1);

  logic [LEN_W-1:0]  sel_len, len_q;
  logic [LANE_W-1:0] sel_lane, lane_q;
  logic [NCNT_W-1:0] sel_nregs, nregs_q;
  logic              cfg_bad, busy;
  logic [IDX_W-1:0]  idx;
  logic [OP_W-1:0]   op_q;
  logic [REG_W-1:0]  src_q, dst_q;

  vuop_fmt_sel #(
    .NUM_FMT(NUM_FMT), .LEN_W(LEN_W), .LANE_W(LANE_W),
    .BYTES_PER_REG(BYTES_PER_REG), .MAX_REGS(MAX_REGS)
  ) u_sel (
    .len_reg_i(cfg_len_i), .lane_reg_i(cfg_lane_i), .fmt_i(in_fmt_i),
    .sel_len_o(sel_len), .sel_lane_o(sel_lane), .nregs_o(sel_nregs),
    .cfg_bad_o(cfg_bad)
  );

  vuop_seq #(
    .LEN_W(LEN_W), .LANE_W(LANE_W), .MAX_REGS(MAX_REGS),
    .REG_W(REG_W), .OP_W(OP_W)
  ) u_seq (
    .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .cfg_bad_i(cfg_bad), .nregs_i(sel_nregs), .len_i(sel_len), .lane_i(sel_lane),
    .op_i(in_opcode_i), .src_i(in_src_i), .dst_i(in_dst_i),
    .uop_ready_i(uop_ready_i), .busy_o(busy), .idx_o(idx), .nregs_q_o(nregs_q),
    .len_q_o(len_q), .lane_q_o(lane_q), .op_q_o(op_q), .src_q_o(src_q),
    .dst_q_o(dst_q), .exc_o(exc_o)
  );

  vuop_emit #(
    .LEN_W(LEN_W), .BYTES_PER_REG(BYTES_PER_REG), .MAX_REGS(MAX_REGS), .REG_W(REG_W)
  ) u_emit (
    .idx_i(idx), .nregs_i(nregs_q), .len_i(len_q), .src_i(src_q), .dst_i(dst_q),
    .src_o(uop_src_o), .dst_o(uop_dst_o), .last_o(uop_last_o),
    .byte_en_o(uop_byte_en_o)
  );

  assign uop_valid_o  = busy;
  assign uop_opcode_o = op_q;
  assign uop_lane_o   = lane_q;
  assign uop_idx_o    = idx;

  AST_SRC_STEP: assert property (@(posedge clk) disable iff (rst)
    uop_valid_o && uop_ready_i && !uop_last_o |=>
      uop_valid_o && (uop_src_o == $past(uop_src_o) + REG_W'(1))); // R4
  AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    uop_valid_o && uop_ready_i && uop_last_o |=> in_ready_o && !uop_valid_o); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    uop_valid_o && !uop_ready_i |=> uop_valid_o && $stable(uop_src_o) &&
      $stable(uop_dst_o) && $stable(uop_byte_en_o) && $stable(uop_last_o)); // R8
  AST_FULL_MASK_EARLY: assert property (@(posedge clk) disable iff (rst)
    uop_valid_o && !uop_last_o |-> (&uop_byte_en_o)); // R5
  AST_EXC_NO_UOP: assert property (@(posedge clk) disable iff (rst)
    exc_o |-> !uop_valid_o); // R7
endmodule

// File: tb/vuop_expander_tb.sv
`timescale 1ns/1ps
module vuop_expander_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [55:0] cfg_len = '0;
  logic [23:0] cfg_lane = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0;
  logic [2:0]  in_fmt = '0;
  logic [5:0]  in_src = '0, in_dst = '0;
  logic        uop_valid;
  logic        uop_ready = 1'b1;
  logic [7:0]  uop_opcode;
  logic [5:0]  uop_src, uop_dst;
  logic [2:0]  uop_lane, uop_idx;
  logic        uop_last;
  logic [7:0]  uop_byte_en;
  logic        exc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vuop_expander u_dut (
    .clk(clk), .rst(rst), .cfg_len_i(cfg_len), .cfg_lane_i(cfg_lane),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_opcode_i(in_opcode),
    .in_fmt_i(in_fmt), .in_src_i(in_src), .in_dst_i(in_dst),
    .uop_valid_o(uop_valid), .uop_ready_i(uop_ready), .uop_opcode_o(uop_opcode),
    .uop_src_o(uop_src), .uop_dst_o(uop_dst), .uop_lane_o(uop_lane),
    .uop_idx_o(uop_idx), .uop_last_o(uop_last), .uop_byte_en_o(uop_byte_en),
    .exc_o(exc)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_field(input int f, input int len, input int lane);
    cfg_len[f*7 +: 7]  = 7'(len);
    cfg_lane[f*3 +: 3] = 3'(lane);
  endtask

  task automatic issue(input int f, input logic [7:0] op, input logic [5:0] s, input logic [5:0] d);
    in_fmt = 3'(f); in_opcode = op; in_src = s; in_dst = d; in_valid = 1'b1;
    step();
    in_valid = 1'b0;
  endtask

  // consume the expected run; stall_k selects one beat held back a cycle
  task automatic drain(input int len, input int lane, input logic [7:0] op,
                       input logic [5:0] s, input logic [5:0] d, input int stall_k);
    int n;
    n = (len + 7) / 8;
    for (int k = 0; k < n; k++) begin
      logic [7:0] m;
      for (int b = 0; b < 8; b++) m[b] = (8*k + b < len);
      if (k == stall_k) begin
        logic [5:0] held_src;
        logic [7:0] held_en;
        held_src = uop_src; held_en = uop_byte_en;
        uop_ready = 1'b0;
        step();
        chk("R8 valid held", uop_valid, 1);
        chk("R8 src held", uop_src, held_src);
        chk("R8 mask held", uop_byte_en, held_en);
        uop_ready = 1'b1;
      end
      chk("R3 valid", uop_valid, 1);
      chk("R4 idx", uop_idx, k);
      chk("R4 src", uop_src, 6'(s + 6'(k)));
      chk("R4 dst", uop_dst, 6'(d + 6'(k)));
      chk("R5 last", uop_last, (k == n-1));
      chk("R5 mask", uop_byte_en, m);
      chk("R6 opcode", uop_opcode, op);
      chk("R6 lane", uop_lane, lane);
      chk("R9 busy", in_ready, 0);
      step();
    end
    chk("R9 release valid", uop_valid, 0);
    chk("R9 release ready", in_ready, 1);
  endtask

  task automatic t_reset();
    chk("R1 in_ready", in_ready, 1);
    chk("R1 uop_valid", uop_valid, 0);
    chk("R1 exc", exc, 0);
  endtask

  task automatic t_select();
    // R2: distinct fields, pick a middle one
    for (int f = 0; f < 8; f++) set_field(f, 8*f + 3, f % 5);
    issue(5, 8'h3C, 6'd10, 6'd20);
    drain(43, 0, 8'h3C, 6'd10, 6'd20, -1);
    issue(2, 8'hA1, 6'd0, 6'd32);
    drain(19, 2, 8'hA1, 6'd0, 6'd32, -1);
  endtask

  task automatic t_lengths();
    set_field(1, 64, 3); issue(1, 8'h11, 6'd4, 6'd5); drain(64, 3, 8'h11, 6'd4, 6'd5, -1);
    set_field(1, 1, 0);  issue(1, 8'h12, 6'd7, 6'd9); drain(1, 0, 8'h12, 6'd7, 6'd9, -1);
    set_field(1, 8, 4);  issue(1, 8'h13, 6'd1, 6'd2); drain(8, 4, 8'h13, 6'd1, 6'd2, -1);
    set_field(1, 0, 1);  issue(1, 8'h14, 6'd1, 6'd2);
    chk("R3 zero no uop", uop_valid, 0);
    chk("R3 zero ready", in_ready, 1);
    chk("R3 zero no exc", exc, 0);
  endtask

  task automatic t_wrap_float();
    // R6: byte lane code with a float-style opcode, R4 wrap modulo 64
    set_field(6, 30, 0);
    issue(6, 8'hF7, 6'd62, 6'd63);
    drain(30, 0, 8'hF7, 6'd62, 6'd63, -1);
  endtask

  task automatic t_illegal();
    for (int code = 5; code < 8; code++) begin
      set_field(4, 16, code);
      issue(4, 8'h20, 6'd0, 6'd0);
      chk("R7 exc pulse", exc, 1);
      chk("R7 no uop", uop_valid, 0);
      step();
      chk("R7 exc drops", exc, 0);
      chk("R7 still no uop", uop_valid, 0);
    end
    set_field(4, 65, 1);
    issue(4, 8'h21, 6'd0, 6'd0);
    chk("R7 long exc", exc, 1);
    chk("R7 long no uop", uop_valid, 0);
    step();
    chk("R7 long exc drops", exc, 0);
  endtask

  task automatic t_stall();
    set_field(3, 40, 2);
    issue(3, 8'h55, 6'd12, 6'd24);
    drain(40, 2, 8'h55, 6'd12, 6'd24, 2);
    issue(3, 8'h56, 6'd1, 6'd1);
    drain(40, 2, 8'h56, 6'd1, 6'd1, 4);
  endtask

  task automatic t_snapshot();
    set_field(7, 21, 1);
    issue(7, 8'h66, 6'd3, 6'd6);
    set_field(7, 64, 4);   // R10: rewrite after acceptance
    drain(21, 1, 8'h66, 6'd3, 6'd6, 1);
  endtask

  task automatic t_reset_mid();
    set_field(0, 40, 3);
    issue(0, 8'h77, 6'd0, 6'd0);
    step(); step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R11 run dropped", uop_valid, 0);
    chk("R11 ready after reset", in_ready, 1);
    step();
    chk("R11 stays dropped", uop_valid, 0);
    issue(0, 8'h78, 6'd8, 6'd9);
    drain(40, 3, 8'h78, 6'd8, 6'd9, -1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 1'b0;
    t_reset();
    t_select();
    t_lengths();
    t_wrap_float();
    t_illegal();
    t_stall();
    t_snapshot();
    t_reset_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule